// File: doc/BRIEF.md
# Status-Polled Flash Bank Programmer

This block erases or programs one bank of a byte-wide flash device that is driven through command bytes and a status register. A request carries an operation (erase or program) and a bank index. The bank occupies `BANK_BYTES` consecutive bytes, and its base address is the bank index multiplied by `BANK_BYTES`. The block then drives one bus cycle per clock: command writes, data writes, status reads and array reads.

Program data comes from an external byte source. The block presents an offset within the bank on `src_offset`. The source must answer combinationally on `src_data` in the same cycle. Every operation polls the device for completion, with a bound on the number of attempts. After polling the block always issues a clear-status command and a return-to-array command. It then reads back the whole bank and compares each byte. The outcome is reported as a one-cycle `done` pulse with a two-bit result code. Codes: 0 success, 1 poll timeout, 2 verify mismatch, 3 device error status.

Top module: `flash_bank_prog`

## Requirements
- R1: An erase request (`req_op`=0) begins with a write of 0x20 to the bank base address, followed on the next bus cycle by a write of 0xD0 to the same address.
- R2: The bank base address equals `req_bank` × `BANK_BYTES`. Every bus cycle of an operation addresses a byte inside that bank, and `fl_we` and `fl_re` are never high together.
- R3: A poll attempt consists of a write of 0x70 to the base address followed by a read of the status byte. The device is ready when status bit 7 is set. If `POLL_LIMIT` attempts pass without readiness, the result is code 1.
- R4: Once polling ends, for any reason, the block writes 0x50 and then 0xFF to the base address. These two writes are its last two writes of the operation.
- R5: After a successful erase, each bank byte must read 0xFF. After a successful program, each byte must equal `src_data` for its offset. Bytes are read in ascending offset order. The first mismatch ends the operation with code 2.
- R6: Programming a byte means writing 0x40 to the target address, waiting `SETUP_CYCLES` idle cycles, writing the data byte to the same address, and then polling. Bytes are programmed from offset 0 upward.
- R7: A poll timeout while programming ends the byte loop. No further byte is programmed and no read-back is made.
- R8: A ready status with any of bits 5..3 set (mask 0x38) ends the operation with code 3, without read-back.
- R9: A request is taken only while `busy` is low. A request made while busy is ignored and produces no extra `done`.
- R10: After reset, `busy`, `done`, `err_code`, `fl_we` and `fl_re` are 0. `done` is a single-cycle pulse with `busy` low. `err_code` holds its value until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Start request, sampled while idle |
| req_op | input | 1 | 0 erase, 1 program |
| req_bank | input | BANK_W | Bank index |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err_code | output | 2 | 0 ok, 1 timeout, 2 verify, 3 device error |
| src_offset | output | log2(BANK_BYTES) | Offset of the byte wanted from the source |
| src_data | input | 8 | Source byte for `src_offset`, same cycle |
| fl_addr | output | BANK_W+log2(BANK_BYTES) | Flash byte address |
| fl_wdata | output | 8 | Flash write data |
| fl_we | output | 1 | One-cycle flash write strobe |
| fl_re | output | 1 | One-cycle flash read strobe |
| fl_rdata | input | 8 | Read data, valid the cycle after `fl_re` |

## Verification
The assertions assume several things about the environment. The flash returns read data exactly one cycle after `fl_re` and holds it otherwise. `src_data` depends only on `src_offset`, so the same byte is seen when programming and when verifying. Requests may arrive at any time, including while busy. The bench flash model registers its read data on the read strobe and computes its source bytes from the offset alone. It raises `req_valid` in the middle of a running operation to test that the request is dropped.

// File: rtl/flash_bank_prog.sv
module flash_bank_prog #(
  parameter int BANK_BYTES   = 8192,
  parameter int BANK_W       = 1,
  parameter int SETUP_CYCLES = 50,
  parameter int POLL_LIMIT   = 1000000
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   req_valid,
  input  logic                                   req_op,
  input  logic [BANK_W-1:0]                      req_bank,
  output logic                                   busy,
  output logic                                   done,
  output logic [1:0]                             err_code,
  output logic [$clog2(BANK_BYTES)-1:0]          src_offset,
  input  logic [7:0]                             src_data,
  output logic [BANK_W+$clog2(BANK_BYTES)-1:0]   fl_addr,
  output logic [7:0]                             fl_wdata,
  output logic                                   fl_we,
  output logic                                   fl_re,
  input  logic [7:0]                             fl_rdata
);
  localparam int OFF_W = $clog2(BANK_BYTES);
  localparam int AW    = BANK_W + OFF_W;
  localparam int PW    = $clog2(POLL_LIMIT + 1);
  localparam int WW    = $clog2(SETUP_CYCLES + 1);
  localparam logic [OFF_W-1:0] LAST = OFF_W'(BANK_BYTES - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_ESET, S_ECONF, S_PSET, S_PWAIT, S_PDATA, S_QCMD,
    S_QRD, S_QCHK, S_CLR, S_RST, S_VRD, S_VCHK, S_FIN
  } st_t;

  st_t               state;
  logic              op_q;
  logic [BANK_W-1:0] bank_q;
  logic [OFF_W-1:0]  idx;
  logic [WW-1:0]     wcnt;
  logic [PW-1:0]     pcnt;
  logic [1:0]        err_q;
  logic              done_q;

  logic [AW-1:0] base_addr, tgt_addr;
  logic [7:0]    expect_byte;
  logic          on_target;

  assign base_addr   = {bank_q, {OFF_W{1'b0}}};
  assign tgt_addr    = {bank_q, idx};
  assign on_target   = (state == S_PSET) || (state == S_PDATA) || (state == S_VRD);
  assign fl_addr     = on_target ? tgt_addr : base_addr;
  assign fl_re       = (state == S_QRD) || (state == S_VRD);
  assign fl_we       = (state == S_ESET) || (state == S_ECONF) || (state == S_PSET) ||
                       (state == S_PDATA) || (state == S_QCMD) || (state == S_CLR) ||
                       (state == S_RST);
  assign src_offset  = idx;
  assign expect_byte = op_q ? src_data : 8'hFF;
  assign busy        = (state != S_IDLE);
  assign done        = done_q;
  assign err_code    = err_q;

  always_comb begin
    case (state)
      S_ESET:  fl_wdata = 8'h20;
      S_ECONF: fl_wdata = 8'hD0;
      S_PSET:  fl_wdata = 8'h40;
      S_PDATA: fl_wdata = src_data;
      S_QCMD:  fl_wdata = 8'h70;
      S_CLR:   fl_wdata = 8'h50;
      S_RST:   fl_wdata = 8'hFF;
      default: fl_wdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      op_q   <= 1'b0;
      bank_q <= '0;
      idx    <= '0;
      wcnt   <= '0;
      pcnt   <= '0;
      err_q  <= 2'd0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (req_valid) begin
          op_q   <= req_op;
          bank_q <= req_bank;
          idx    <= '0;
          err_q  <= 2'd0;
          state  <= req_op ? S_PSET : S_ESET;
        end
        S_ESET:  state <= S_ECONF;
        S_ECONF: begin pcnt <= '0; state <= S_QCMD; end
        S_PSET:  begin wcnt <= '0; state <= S_PWAIT; end
        S_PWAIT: begin
          if (wcnt == WW'(SETUP_CYCLES - 1)) state <= S_PDATA;
          else wcnt <= wcnt + 1'b1;
        end
        S_PDATA: begin pcnt <= '0; state <= S_QCMD; end
        S_QCMD:  state <= S_QRD;
        S_QRD:   state <= S_QCHK;
        S_QCHK: begin
          if (fl_rdata[7]) begin
            if ((fl_rdata & 8'h38) != 8'h00) begin
              err_q <= 2'd3;
              state <= S_CLR;
            end else if (!op_q || idx == LAST) begin
              state <= S_CLR;
            end else begin
              idx   <= idx + 1'b1;
              state <= S_PSET;
            end
          end else if (pcnt == PW'(POLL_LIMIT - 1)) begin
            err_q <= 2'd1;
            state <= S_CLR;
          end else begin
            pcnt  <= pcnt + 1'b1;
            state <= S_QCMD;
          end
        end
        S_CLR: state <= S_RST;
        S_RST: begin
          if (err_q != 2'd0) state <= S_FIN;
          else begin
            idx   <= '0;
            state <= S_VRD;
          end
        end
        S_VRD: state <= S_VCHK;
        S_VCHK: begin
          if (fl_rdata != expect_byte) begin
            err_q <= 2'd2;
            state <= S_FIN;
          end else if (idx == LAST) begin
            state <= S_FIN;
          end else begin
            idx   <= idx + 1'b1;
            state <= S_VRD;
          end
        end
        S_FIN: begin
          done_q <= 1'b1;
          state  <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_bank_prog_chk.sv
module flash_bank_prog_chk #(
  parameter int OFF_W = 13,
  parameter int AW    = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic [1:0]    err_code,
  input logic [AW-1:0] fl_addr,
  input logic          fl_we,
  input logic          fl_re
);
  p_bus_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we && fl_re));

  p_bank_fixed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(fl_addr[AW-1:OFF_W]));

  p_bus_only_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we || fl_re) |-> busy);

  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy));

  p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_err_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !$past(busy) |-> $stable(err_code));
endmodule

bind flash_bank_prog flash_bank_prog_chk #(.OFF_W(OFF_W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err_code(err_code),
  .fl_addr(fl_addr), .fl_we(fl_we), .fl_re(fl_re)
);

// File: tb/test_flash_bank_prog.sv
module test_flash_bank_prog;
  localparam int BB    = 16;
  localparam int BW    = 1;
  localparam int SETUP = 3;
  localparam int PLIM  = 8;
  localparam int OW    = $clog2(BB);
  localparam int AW    = BW + OW;
  localparam int NB    = 2 ** BW;
  localparam int ERASE_POLLS = 4;
  localparam int PGM_POLLS   = 1;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_op = 0;
  logic [BW-1:0] req_bank = '0;
  logic busy, done, fl_we, fl_re;
  logic [1:0] err_code;
  logic [OW-1:0] src_offset;
  logic [7:0] src_data, fl_wdata;
  logic [7:0] fl_rdata = 8'h00;
  logic [AW-1:0] fl_addr;

  always #10 clk = ~clk;

  int errors = 0, checks = 0, cyc = 0;
  logic [7:0] seed = 8'h00;
  assign src_data = 8'h3C + 8'(src_offset) * 8'd11 + seed;

  function automatic logic [7:0] pat(int off);
    return 8'h3C + 8'(off) * 8'd11 + seed;
  endfunction

  flash_bank_prog #(.BANK_BYTES(BB), .BANK_W(BW), .SETUP_CYCLES(SETUP), .POLL_LIMIT(PLIM))
  i_flash_bank_prog (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op), .req_bank(req_bank),
    .busy(busy), .done(done), .err_code(err_code), .src_offset(src_offset), .src_data(src_data),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_we(fl_we), .fl_re(fl_re), .fl_rdata(fl_rdata)
  );

  // flash device model
  logic [7:0] mem [0:NB*BB-1];
  logic status_mode = 0, erase_armed = 0, pgm_armed = 0;
  int   busy_polls = 0;
  logic stuck = 0;
  logic [7:0] inj_err = 8'h00;
  logic corrupt = 0;
  int   corrupt_addr = 0;
  logic [AW-1:0] la[$];
  logic [7:0]    ld[$];
  int            lt[$];
  int nrd_arr = 0, nrd_st = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (fl_we) begin
      la.push_back(fl_addr); ld.push_back(fl_wdata); lt.push_back(cyc);
      if (pgm_armed) begin
        mem[fl_addr] <= mem[fl_addr] & ((corrupt && int'(fl_addr) == corrupt_addr) ? (fl_wdata ^ 8'h01) : fl_wdata);
        pgm_armed <= 0; busy_polls <= PGM_POLLS; status_mode <= 1;
      end else begin
        case (fl_wdata)
          8'h20: erase_armed <= 1;
          8'hD0: if (erase_armed) begin
            for (int i = 0; i < BB; i++) mem[(int'(fl_addr) / BB) * BB + i] <= 8'hFF;
            erase_armed <= 0; busy_polls <= ERASE_POLLS; status_mode <= 1;
          end
          8'h40: pgm_armed <= 1;
          8'h70: status_mode <= 1;
          8'hFF: status_mode <= 0;
          default: ;
        endcase
      end
    end
    if (fl_re) begin
      if (status_mode) begin
        nrd_st <= nrd_st + 1;
        if (stuck) fl_rdata <= 8'h00;
        else if (busy_polls > 0) begin busy_polls <= busy_polls - 1; fl_rdata <= 8'h00; end
        else fl_rdata <= 8'h80 | inj_err;
      end else begin
        nrd_arr <= nrd_arr + 1;
        fl_rdata <= mem[fl_addr];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // scoreboard
  logic [1:0] exp_q[$];
  int n_done = 0;
  always @(negedge clk) begin
    if (rst_n && done) begin
      n_done++;
      if (exp_q.size() == 0) chk(0, "R9", "unexpected done", 1, 0);
      else begin
        logic [1:0] e;
        e = exp_q.pop_front();
        chk(err_code == e, "R10", "result code", err_code, e);
        chk(!busy, "R10", "busy low at done", busy, 0);
      end
    end
  end

  task automatic run_op(input logic op, input int bank, input logic [1:0] exp, input bit poke_busy);
    la.delete(); ld.delete(); lt.delete();
    nrd_arr = 0; nrd_st = 0;
    exp_q.push_back(exp);
    @(negedge clk);
    req_valid = 1; req_op = op; req_bank = BW'(bank);
    @(negedge clk);
    req_valid = 0;
    if (poke_busy) begin
      repeat (3) @(negedge clk);
      req_valid = 1; req_op = 1; req_bank = BW'(bank ^ 1);
      repeat (2) @(negedge clk);
      req_valid = 0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic int count_wr(logic [7:0] v);
    int n = 0;
    foreach (ld[i]) if (ld[i] == v) n++;
    return n;
  endfunction

  task automatic chk_tail(input int base);
    int n;
    n = ld.size();
    chk(n >= 2 && ld[n-2] == 8'h50 && int'(la[n-2]) == base, "R4", "clear-status write", n >= 2 ? ld[n-2] : -1, 8'h50);
    chk(n >= 2 && ld[n-1] == 8'hFF && int'(la[n-1]) == base, "R4", "reset write", n >= 1 ? ld[n-1] : -1, 8'hFF);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog", "run hung", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < NB*BB; i++) mem[i] = 8'h5A ^ 8'(i);
    repeat (3) @(negedge clk);
    chk(!busy && !done && err_code == 0 && !fl_we && !fl_re, "R10", "reset outputs",
        {busy, done, err_code, fl_we, fl_re}, 0);
    rst_n = 1;
    @(negedge clk);

    // R1 R5 erase bank 0
    run_op(0, 0, 2'd0, 0);
    chk(ld.size() >= 2 && ld[0] == 8'h20 && la[0] == 0, "R1", "erase setup", ld[0], 8'h20);
    chk(ld.size() >= 2 && ld[1] == 8'hD0 && la[1] == 0, "R1", "erase confirm", ld[1], 8'hD0);
    begin
      int bad = 0;
      for (int i = 0; i < BB; i++) if (mem[i] != 8'hFF) bad++;
      chk(bad == 0, "R5", "bank 0 erased", bad, 0);
    end
    chk(nrd_arr == BB, "R5", "erase read-back length", nrd_arr, BB);
    chk_tail(0);

    // R6 R2 program bank 1 (pre-erased)
    for (int i = 0; i < BB; i++) mem[BB + i] = 8'hFF;
    seed = 8'h01;
    run_op(1, 1, 2'd0, 0);
    begin
      int bad = 0, outside = 0;
      for (int i = 0; i < BB; i++) if (mem[BB + i] != pat(i)) bad++;
      chk(bad == 0, "R6", "bank 1 contents", bad, 0);
      foreach (la[i]) if (int'(la[i]) < BB) outside++;
      chk(outside == 0, "R2", "writes outside bank 1", outside, 0);
    end
    chk(ld[0] == 8'h40 && int'(la[0]) == BB, "R6", "program setup", ld[0], 8'h40);
    chk(ld[1] == pat(0) && int'(la[1]) == BB, "R6", "program data byte", ld[1], pat(0));
    chk(lt[1] - lt[0] >= SETUP + 1, "R6", "setup wait cycles", lt[1] - lt[0], SETUP + 1);
    chk(nrd_arr == BB, "R5", "program read-back length", nrd_arr, BB);
    chk_tail(BB);

    // R9 request while busy ignored
    run_op(0, 1, 2'd0, 1);
    repeat (5) @(negedge clk);
    chk(!busy, "R9", "no second operation started", busy, 0);
    chk(n_done == 3, "R9", "done count", n_done, 3);
    chk(err_code == 0, "R10", "err_code held", err_code, 0);

    // R3 R7 timeout while programming bank 0
    seed = 8'h00;
    stuck = 1;
    run_op(1, 0, 2'd1, 0);
    stuck = 0;
    chk(nrd_st == PLIM, "R3", "poll attempts", nrd_st, PLIM);
    chk(count_wr(8'h40) == 1, "R7", "bytes started", count_wr(8'h40), 1);
    chk(nrd_arr == 0, "R7", "no read-back", nrd_arr, 0);
    chk_tail(0);
    repeat (4) @(negedge clk);
    chk(err_code == 2'd1, "R10", "timeout code held", err_code, 1);

    // R3 erase timeout bank 1
    stuck = 1;
    run_op(0, 1, 2'd1, 0);
    stuck = 0;
    chk(nrd_st == PLIM, "R3", "erase poll attempts", nrd_st, PLIM);

    // R8 device error status
    inj_err = 8'h10;
    run_op(0, 0, 2'd3, 0);
    inj_err = 8'h00;
    chk(nrd_arr == 0, "R8", "no read-back on device error", nrd_arr, 0);
    chk_tail(0);

    // R5 verify mismatch
    for (int i = 0; i < BB; i++) mem[i] = 8'hFF;
    corrupt = 1; corrupt_addr = 5;
    run_op(1, 0, 2'd2, 0);
    corrupt = 0;
    chk(nrd_arr == 6, "R5", "read-back stops at first mismatch", nrd_arr, 6);

    chk(exp_q.size() == 0, "R10", "all results seen", exp_q.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule